// File: doc/BRIEF.md
# Transactional Line Conflict Tracker

This block follows the working set of one core's best-effort hardware transaction. The core opens a transaction with a begin command. From then on, the block records the cache lines that the transaction reads and writes in a small table, at 64-byte line granularity. Lines are added in two ways: speculative local accesses, and watch commands that arm conflict detection without moving data. A release command drops an unmodified line from the table.

Every remote read or write seen on the snoop port is checked against the table, whether or not it comes from another transaction. The policy is requester-wins: a conflicting remote request goes ahead, and the local transaction is aborted. Other abort causes are:
- a fifth distinct line, which exceeds the table,
- an external interrupt or exception event,
- a voluntary abort carrying a software code.

On an abort, the block first names each written line, one per cycle, so that the cache can discard its speculative data. It then reports the abort status and returns to idle. On a commit, it clears the table in a single cycle.

A begin variant selects the inverted mode. In that mode, plain accesses are speculative and annotated accesses bypass tracking. A replayed access has already been resolved, so it is never inverted a second time.

Top module: `txn_conflict_tracker`

## Requirements
- R1: Lines are compared on address bits [ADDR_W-1:6] only; the low six offset bits never affect a hit.
- R2: Command codes are 0 nop, 1 begin, 2 begin-inverted, 3 commit, 4 abort, 5 release, 6 watch-read, 7 watch-write. A begin from idle raises tx_active_o after the edge. An outermost commit clears the table, drops tx_active_o and pulses commit_done_o high for exactly one cycle.
- R3: The table holds ENTRIES (4) distinct lines. A speculative access or watch to a new line when all entries are in use aborts with cause capacity, code 0x20.
- R4: A remote write that hits any tracked line aborts with cause conflict, code 0x10. A remote read aborts only if it hits a line in the write set. A remote read of a read-only line is harmless.
- R5: Remote requests are checked whatever their origin. Snoops, accesses and commands (other than begin) seen while no transaction is active have no effect.
- R6: A remote request and a local insert to the same line in the same cycle resolve in favour of the remote request, which aborts the transaction.
- R7: Watch-read adds a line to the read set and watch-write adds it to the write set, with no access.
- R8: Release removes a tracked line only if it is not in the write set. A release of a written line leaves it tracked.
- R9: The abort code is {cause[3:0], sw_code[3:0]}. The causes are 1 conflict, 2 capacity, 3 external, 4 voluntary, with the software code kept only for voluntary. When several causes arrive together, the order is conflict over external over voluntary over capacity. abort_code_o is zero whenever abort_valid_o is low.
- R10: In normal mode only annotated accesses are tracked. After a begin-inverted command, unannotated accesses are tracked and annotated ones bypass the table.
- R11: An access flagged as a replay uses its annotation as the final speculative flag, with no inversion in either mode.
- R12: On abort, the written lines are named one per cycle on rollback_line_o, lowest entry first. The cycle after the last one, abort_valid_o pulses once with the code, the table is empty and the block is idle.
- R13: A begin during an active transaction only increments a nesting depth and keeps the table. A commit at nonzero depth only decrements it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (R2) |
| cmd_addr_i | input | ADDR_W | Address for release and watch |
| cmd_code_i | input | VCODE_W | Software code for voluntary abort |
| acc_valid_i | input | 1 | Local access strobe |
| acc_write_i | input | 1 | Local access is a store |
| acc_annot_i | input | 1 | Access carries the speculation annotation |
| acc_replay_i | input | 1 | Access is a replay, already resolved |
| acc_addr_i | input | ADDR_W | Local access address |
| snp_valid_i | input | 1 | Remote request strobe |
| snp_write_i | input | 1 | Remote request is a write |
| snp_addr_i | input | ADDR_W | Remote request address |
| ext_abort_i | input | 1 | Interrupt or exception event |
| tx_active_o | output | 1 | Transaction open and tracking |
| commit_done_o | output | 1 | One-cycle commit pulse |
| abort_valid_o | output | 1 | One-cycle abort report |
| abort_code_o | output | 4+VCODE_W | Abort status |
| rollback_valid_o | output | 1 | A written line is being named |
| rollback_line_o | output | ADDR_W-6 | Line address to discard |

## Verification
The bench builds the block with its defaults: 32-bit addresses, four entries, a three-bit nesting depth and a four-bit software code. With four entries, a full table and the capacity abort on the fifth line take only a handful of accesses. A full rollback walk can then be checked line by line. The 32-bit address lets a directed case place two lines that differ only in the top bits, which shows that the whole line field is compared. Snoop offsets differ from local access offsets throughout, which shows that the offset bits play no part.

// File: rtl/txct_pkg.sv
package txct_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_BEGIN = 3'd1, OP_BEGIN_INV = 3'd2, OP_COMMIT = 3'd3,
    OP_ABORT = 3'd4, OP_RELEASE = 3'd5, OP_WATCH_R = 3'd6, OP_WATCH_W = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    CAUSE_NONE = 4'd0, CAUSE_CONFLICT = 4'd1, CAUSE_CAPACITY = 4'd2,
    CAUSE_EXTERNAL = 4'd3, CAUSE_VOLUNTARY = 4'd4
  } cause_e;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACTIVE = 2'd1, ST_UNWIND = 2'd2} state_e;
endpackage

// File: rtl/txct_insert.sv
module txct_insert #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic                           en_i,
  input  logic                           wr_i,
  input  logic [LINE_W-1:0]              line_i,
  input  logic [ENTRIES-1:0]             vld_i,
  input  logic [ENTRIES-1:0]             rd_i,
  input  logic [ENTRIES-1:0]             wr_set_i,
  input  logic [ENTRIES-1:0][LINE_W-1:0] lines_i,
  output logic [ENTRIES-1:0]             vld_o,
  output logic [ENTRIES-1:0]             rd_o,
  output logic [ENTRIES-1:0]             wr_set_o,
  output logic [ENTRIES-1:0][LINE_W-1:0] lines_o,
  output logic                           full_o
);
  logic [ENTRIES-1:0] hit;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_hit
    assign hit[k] = vld_i[k] && (lines_i[k] == line_i);
  end

  always_comb begin
    logic placed;
    vld_o    = vld_i;
    rd_o     = rd_i;
    wr_set_o = wr_set_i;
    lines_o  = lines_i;
    full_o   = 1'b0;
    placed   = 1'b0;
    if (en_i) begin
      if (|hit) begin
        for (int k = 0; k < ENTRIES; k++) begin
          if (hit[k]) begin
            rd_o[k]     = rd_i[k] | ~wr_i;
            wr_set_o[k] = wr_set_i[k] | wr_i;
          end
        end
      end else begin
        for (int k = 0; k < ENTRIES; k++) begin
          if (!placed && !vld_i[k]) begin
            placed      = 1'b1;
            vld_o[k]    = 1'b1;
            rd_o[k]     = ~wr_i;
            wr_set_o[k] = wr_i;
            lines_o[k]  = line_i;
          end
        end
        full_o = ~placed;
      end
    end
  end
endmodule

// File: rtl/txct_snoop_match.sv
module txct_snoop_match #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic                           snp_valid_i,
  input  logic                           snp_write_i,
  input  logic [LINE_W-1:0]              snp_line_i,
  input  logic [ENTRIES-1:0]             vld_i,
  input  logic [ENTRIES-1:0]             wr_set_i,
  input  logic [ENTRIES-1:0][LINE_W-1:0] lines_i,
  output logic                           conflict_o
);
  logic [ENTRIES-1:0] hit;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
    assign hit[k] = vld_i[k] && (lines_i[k] == snp_line_i);
  end

  // requester wins: any write hit, or a read hitting the write set
  assign conflict_o = snp_valid_i && (snp_write_i ? |hit : |(hit & wr_set_i));
endmodule

// File: rtl/txct_pick_first.sv
module txct_pick_first #(
  parameter int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (mask_i[k]) idx_o = IDX_W'(k);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
  import txct_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int ENTRIES  = 4,
  parameter int NEST_W   = 3,
  parameter int VCODE_W  = 4,
  localparam int LINE_W  = ADDR_W - LINE_OFF,
  localparam int CODE_W  = 4 + VCODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [VCODE_W-1:0] cmd_code_i,
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic               acc_annot_i,
  input  logic               acc_replay_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               snp_valid_i,
  input  logic               snp_write_i,
  input  logic [ADDR_W-1:0]  snp_addr_i,
  input  logic               ext_abort_i,
  output logic               tx_active_o,
  output logic               commit_done_o,
  output logic               abort_valid_o,
  output logic [CODE_W-1:0]  abort_code_o,
  output logic               rollback_valid_o,
  output logic [LINE_W-1:0]  rollback_line_o
);
  localparam int NPORT = 2;
  localparam int IDX_W = $clog2(ENTRIES);

  state_e                     state_q;
  logic [ENTRIES-1:0]         vld_q, rd_q, wr_q;
  logic [ENTRIES-1:0][LINE_W-1:0] lines_q;
  logic                       inv_q;
  logic [NEST_W-1:0]          nest_q;
  logic [CODE_W-1:0]          code_q;
  logic                       commit_done_q;

  logic [LINE_W-1:0] cmd_line, acc_line, snp_line;
  assign cmd_line = cmd_addr_i[ADDR_W-1:LINE_OFF];
  assign acc_line = acc_addr_i[ADDR_W-1:LINE_OFF];
  assign snp_line = snp_addr_i[ADDR_W-1:LINE_OFF];

  logic addr_unused;
  assign addr_unused = ^{cmd_addr_i[LINE_OFF-1:0], acc_addr_i[LINE_OFF-1:0],
                         snp_addr_i[LINE_OFF-1:0]};

  logic in_tx, cmd_begin, cmd_commit, cmd_abort, cmd_rel, cmd_watch;
  assign in_tx      = (state_q == ST_ACTIVE);
  assign cmd_begin  = cmd_valid_i && (cmd_op_i == OP_BEGIN || cmd_op_i == OP_BEGIN_INV);
  assign cmd_commit = cmd_valid_i && (cmd_op_i == OP_COMMIT);
  assign cmd_abort  = cmd_valid_i && (cmd_op_i == OP_ABORT);
  assign cmd_rel    = cmd_valid_i && (cmd_op_i == OP_RELEASE);
  assign cmd_watch  = cmd_valid_i && (cmd_op_i == OP_WATCH_R || cmd_op_i == OP_WATCH_W);

  // replayed accesses arrive already resolved: invert only first-time accesses
  logic acc_spec;
  assign acc_spec = acc_replay_i ? acc_annot_i : (acc_annot_i ^ inv_q);

  // release stage: only unwritten lines may leave
  logic [ENTRIES-1:0] rel_vld;
  always_comb begin
    rel_vld = vld_q;
    for (int k = 0; k < ENTRIES; k++) begin
      if (in_tx && cmd_rel && vld_q[k] && !wr_q[k] && lines_q[k] == cmd_line)
        rel_vld[k] = 1'b0;
    end
  end

  // insert chain: port 0 = watch command, port 1 = local access
  logic [NPORT-1:0]  pt_en, pt_wr, pt_full;
  logic [LINE_W-1:0] pt_line [NPORT];
  assign pt_en[0]   = in_tx && cmd_watch;
  assign pt_wr[0]   = (cmd_op_i == OP_WATCH_W);
  assign pt_line[0] = cmd_line;
  assign pt_en[1]   = in_tx && acc_valid_i && acc_spec;
  assign pt_wr[1]   = acc_write_i;
  assign pt_line[1] = acc_line;

  logic [ENTRIES-1:0]             st_vld   [NPORT+1];
  logic [ENTRIES-1:0]             st_rd    [NPORT+1];
  logic [ENTRIES-1:0]             st_wr    [NPORT+1];
  logic [ENTRIES-1:0][LINE_W-1:0] st_lines [NPORT+1];
  assign st_vld[0]   = rel_vld;
  assign st_rd[0]    = rd_q;
  assign st_wr[0]    = wr_q;
  assign st_lines[0] = lines_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    txct_insert #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_ins (
      .en_i     (pt_en[p]),
      .wr_i     (pt_wr[p]),
      .line_i   (pt_line[p]),
      .vld_i    (st_vld[p]),
      .rd_i     (st_rd[p]),
      .wr_set_i (st_wr[p]),
      .lines_i  (st_lines[p]),
      .vld_o    (st_vld[p+1]),
      .rd_o     (st_rd[p+1]),
      .wr_set_o (st_wr[p+1]),
      .lines_o  (st_lines[p+1]),
      .full_o   (pt_full[p])
    );
  end

  // snoop checked against the post-insert set: remote side wins a same-cycle race
  logic conflict;
  txct_snoop_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_match (
    .snp_valid_i (snp_valid_i),
    .snp_write_i (snp_write_i),
    .snp_line_i  (snp_line),
    .vld_i       (st_vld[NPORT]),
    .wr_set_i    (st_wr[NPORT]),
    .lines_i     (st_lines[NPORT]),
    .conflict_o  (conflict)
  );

  cause_e            cause;
  logic [VCODE_W-1:0] cause_sw;
  always_comb begin
    cause    = CAUSE_NONE;
    cause_sw = '0;
    if (conflict)           cause = CAUSE_CONFLICT;
    else if (ext_abort_i)   cause = CAUSE_EXTERNAL;
    else if (cmd_abort) begin
      cause    = CAUSE_VOLUNTARY;
      cause_sw = cmd_code_i;
    end
    else if (|pt_full)      cause = CAUSE_CAPACITY;
  end

  logic             rb_any;
  logic [IDX_W-1:0] rb_idx;
  txct_pick_first #(.N(ENTRIES)) u_pick (
    .mask_i (vld_q & wr_q),
    .any_o  (rb_any),
    .idx_o  (rb_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      vld_q         <= '0;
      rd_q          <= '0;
      wr_q          <= '0;
      lines_q       <= '0;
      inv_q         <= 1'b0;
      nest_q        <= '0;
      code_q        <= '0;
      commit_done_q <= 1'b0;
    end else begin
      commit_done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_begin) begin
            state_q <= ST_ACTIVE;
            inv_q   <= (cmd_op_i == OP_BEGIN_INV);
            nest_q  <= '0;
          end
        end
        ST_ACTIVE: begin
          vld_q   <= st_vld[NPORT];
          rd_q    <= st_rd[NPORT];
          wr_q    <= st_wr[NPORT];
          lines_q <= st_lines[NPORT];
          if (cause != CAUSE_NONE) begin
            state_q <= ST_UNWIND;
            code_q  <= {cause, cause_sw};
          end else if (cmd_commit) begin
            if (nest_q == '0) begin
              state_q       <= ST_IDLE;
              vld_q         <= '0;
              rd_q          <= '0;
              wr_q          <= '0;
              inv_q         <= 1'b0;
              commit_done_q <= 1'b1;
            end else begin
              nest_q <= nest_q - 1'b1;
            end
          end else if (cmd_begin && nest_q != '1) begin
            nest_q <= nest_q + 1'b1;
          end
        end
        ST_UNWIND: begin
          if (rb_any) begin
            wr_q[rb_idx] <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
            vld_q   <= '0;
            rd_q    <= '0;
            inv_q   <= 1'b0;
            nest_q  <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_active_o      = in_tx;
  assign commit_done_o    = commit_done_q;
  assign rollback_valid_o = (state_q == ST_UNWIND) && rb_any;
  assign rollback_line_o  = rollback_valid_o ? lines_q[rb_idx] : '0;
  assign abort_valid_o    = (state_q == ST_UNWIND) && !rb_any;
  assign abort_code_o     = abort_valid_o ? code_q : '0;
endmodule

// File: rtl/txct_checker.sv
module txct_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic              ext_abort_i,
  input logic              tx_active_o,
  input logic              commit_done_o,
  input logic              abort_valid_o,
  input logic [CODE_W-1:0] abort_code_o,
  input logic              rollback_valid_o
);
  logic unwinding;
  assign unwinding = abort_valid_o || rollback_valid_o;

  p_commit_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_done_o |=> !commit_done_o);

  p_begin_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_active_o && !unwinding && cmd_valid_i && (cmd_op_i == 3'd1 || cmd_op_i == 3'd2))
    |=> tx_active_o);

  p_code_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_valid_o |-> (abort_code_o != '0));

  p_code_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_valid_o |-> (abort_code_o == '0));

  p_ext_aborts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_o && ext_abort_i) |=> (!tx_active_o && unwinding));

  p_abort_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_valid_o |=> (!abort_valid_o && !rollback_valid_o && !tx_active_o));

  p_rb_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_valid_o |-> (!tx_active_o && !abort_valid_o && !commit_done_o));
endmodule

bind txn_conflict_tracker txct_checker #(.CODE_W(CODE_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cmd_valid_i      (cmd_valid_i),
  .cmd_op_i         (cmd_op_i),
  .ext_abort_i      (ext_abort_i),
  .tx_active_o      (tx_active_o),
  .commit_done_o    (commit_done_o),
  .abort_valid_o    (abort_valid_o),
  .abort_code_o     (abort_code_o),
  .rollback_valid_o (rollback_valid_o)
);

// File: tb/txn_conflict_tracker_tb.sv
module txn_conflict_tracker_tb;
  import txct_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LINE_W = ADDR_W - 6;

  typedef struct packed {
    logic [2:0] op;
    logic [3:0] cl;
    logic [3:0] cc;
    logic       av, aw, an, ar;
    logic [3:0] al;
    logic       sv, sw;
    logic [3:0] sl;
    logic       ex;
    logic       e_act, e_cd, e_av;
    logic [7:0] e_code;
    logic       e_rv;
    logic [3:0] e_rl;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 56;
  // fields: op cl cc | av aw an ar al | sv sw sl | ex | act cd av code rv rl | req
  localparam vec_t VEC [NV] = '{
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 2},  // R2 open
    '{OP_NOP,     0,0, 1,1,1,0,1, 0,0,0, 0, 1,0,0,8'h00,0,0, 2},
    '{OP_NOP,     0,0, 1,0,1,0,2, 0,0,0, 0, 1,0,0,8'h00,0,0, 2},
    '{OP_COMMIT,  0,0, 0,0,0,0,0, 0,0,0, 0, 0,1,0,8'h00,0,0, 2},  // R2 commit pulse
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 2},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 10},
    '{OP_NOP,     0,0, 1,1,0,0,3, 1,1,3, 0, 1,0,0,8'h00,0,0, 10}, // R10 plain access untracked
    '{OP_WATCH_R, 4,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 7},
    '{OP_NOP,     0,0, 0,0,0,0,0, 1,0,4, 0, 1,0,0,8'h00,0,0, 4},  // R4 read-read harmless
    '{OP_NOP,     0,0, 0,0,0,0,0, 1,1,4, 0, 0,0,1,8'h10,0,0, 7},  // R7 watched line conflicts
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 12},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 3},
    '{OP_NOP,     0,0, 1,1,1,0,1, 0,0,0, 0, 1,0,0,8'h00,0,0, 3},
    '{OP_WATCH_W, 2,0, 1,0,1,0,3, 0,0,0, 0, 1,0,0,8'h00,0,0, 7},
    '{OP_NOP,     0,0, 1,0,1,0,4, 0,0,0, 0, 1,0,0,8'h00,0,0, 3},
    '{OP_NOP,     0,0, 1,0,1,0,1, 0,0,0, 0, 1,0,0,8'h00,0,0, 3},  // R3 hit needs no entry
    '{OP_NOP,     0,0, 1,0,1,0,5, 0,0,0, 0, 0,0,0,8'h00,1,1, 3},  // R3 fifth line, R12 walk
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,1,2, 12},
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,1,8'h20,0,0, 12},
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 12},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 8},
    '{OP_NOP,     0,0, 1,0,1,0,1, 0,0,0, 0, 1,0,0,8'h00,0,0, 8},
    '{OP_NOP,     0,0, 1,1,1,0,2, 0,0,0, 0, 1,0,0,8'h00,0,0, 8},
    '{OP_RELEASE, 1,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 8},
    '{OP_RELEASE, 2,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 8},
    '{OP_NOP,     0,0, 0,0,0,0,0, 1,1,1, 0, 1,0,0,8'h00,0,0, 8},  // R8 released line free
    '{OP_NOP,     0,0, 0,0,0,0,0, 1,0,2, 0, 0,0,0,8'h00,1,2, 8},  // R8 written kept, R4 read hit
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,1,8'h10,0,0, 4},
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 12},
    '{OP_BEGIN_INV,0,0,0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 10},
    '{OP_NOP,     0,0, 1,0,0,0,1, 0,0,0, 0, 1,0,0,8'h00,0,0, 10},
    '{OP_NOP,     0,0, 1,1,1,0,2, 0,0,0, 0, 1,0,0,8'h00,0,0, 10},
    '{OP_NOP,     0,0, 1,0,1,1,3, 0,0,0, 0, 1,0,0,8'h00,0,0, 11},
    '{OP_NOP,     0,0, 0,0,0,0,0, 1,1,2, 0, 1,0,0,8'h00,0,0, 10}, // R10 annotated bypassed
    '{OP_NOP,     0,0, 0,0,0,0,0, 1,1,3, 0, 0,0,1,8'h10,0,0, 11}, // R11 replay tracked
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 11},
    '{OP_BEGIN_INV,0,0,0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 10},
    '{OP_NOP,     0,0, 1,1,0,0,1, 0,0,0, 0, 1,0,0,8'h00,0,0, 10},
    '{OP_NOP,     0,0, 0,0,0,0,0, 1,0,1, 0, 0,0,0,8'h00,1,1, 10}, // R10 plain store tracked
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,1,8'h10,0,0, 12},
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 12},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 13},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 13},
    '{OP_COMMIT,  0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 13}, // R13 inner commit
    '{OP_COMMIT,  0,0, 0,0,0,0,0, 0,0,0, 0, 0,1,0,8'h00,0,0, 13},
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 13},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 9},
    '{OP_ABORT,   0,5, 0,0,0,0,0, 0,0,0, 0, 0,0,1,8'h45,0,0, 9},  // R9 voluntary
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 9},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 9},
    '{OP_ABORT,   0,7, 0,0,0,0,0, 0,0,0, 1, 0,0,1,8'h30,0,0, 9},  // R9 external beats voluntary
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 9},
    '{OP_BEGIN,   0,0, 0,0,0,0,0, 0,0,0, 0, 1,0,0,8'h00,0,0, 6},
    '{OP_NOP,     0,0, 1,0,1,0,6, 1,1,6, 0, 0,0,1,8'h10,0,0, 6},  // R6 remote wins race
    '{OP_NOP,     0,0, 0,0,0,0,0, 0,0,0, 0, 0,0,0,8'h00,0,0, 6},
    '{OP_RELEASE, 1,0, 1,1,1,0,1, 1,1,1, 1, 0,0,0,8'h00,0,0, 5}   // R5 idle ignores all
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i;
  logic [2:0]        cmd_op_i;
  logic [ADDR_W-1:0] cmd_addr_i;
  logic [3:0]        cmd_code_i;
  logic              acc_valid_i, acc_write_i, acc_annot_i, acc_replay_i;
  logic [ADDR_W-1:0] acc_addr_i;
  logic              snp_valid_i, snp_write_i;
  logic [ADDR_W-1:0] snp_addr_i;
  logic              ext_abort_i;
  logic              tx_active_o, commit_done_o, abort_valid_o, rollback_valid_o;
  logic [7:0]        abort_code_o;
  logic [LINE_W-1:0] rollback_line_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  txn_conflict_tracker u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_code_i,
    .acc_valid_i, .acc_write_i, .acc_annot_i, .acc_replay_i, .acc_addr_i,
    .snp_valid_i, .snp_write_i, .snp_addr_i, .ext_abort_i,
    .tx_active_o, .commit_done_o, .abort_valid_o, .abort_code_o,
    .rollback_valid_o, .rollback_line_o
  );

  task automatic idle_inputs();
    cmd_valid_i = 0; cmd_op_i = 0; cmd_addr_i = 0; cmd_code_i = 0;
    acc_valid_i = 0; acc_write_i = 0; acc_annot_i = 0; acc_replay_i = 0; acc_addr_i = 0;
    snp_valid_i = 0; snp_write_i = 0; snp_addr_i = 0; ext_abort_i = 0;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {14'd0, tx_active_o, commit_done_o, abort_valid_o, abort_code_o,
            rollback_valid_o, rollback_line_o[3:0], 3'd0};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    #(CLK_PERIOD * 2);
    // reset state, R2
    check(outs() == 32'd0, "R2 reset", outs(), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(outs() == 32'd0, "R2 after reset", outs(), 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp;
      vec_t v;
      v = VEC[i];
      cmd_valid_i  = (v.op != OP_NOP);
      cmd_op_i     = v.op;
      cmd_addr_i   = (32'(v.cl) << 6) | 32'h05;
      cmd_code_i   = v.cc;
      acc_valid_i  = v.av; acc_write_i = v.aw; acc_annot_i = v.an; acc_replay_i = v.ar;
      acc_addr_i   = (32'(v.al) << 6) | 32'h11;
      snp_valid_i  = v.sv; snp_write_i = v.sw;
      snp_addr_i   = (32'(v.sl) << 6) | 32'h3a;  // R1 offsets differ from local side
      ext_abort_i  = v.ex;
      @(posedge clk_i);
      @(negedge clk_i);
      exp = {14'd0, v.e_act, v.e_cd, v.e_av, v.e_code, v.e_rv, v.e_rl, 3'd0};
      n_chk++;
      if (outs() != exp) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: got %0h expected %0h", v.req, i, outs(), exp);
      end
    end
    idle_inputs();

    // R1: lines differing only in high bits are distinct
    cmd_valid_i = 1; cmd_op_i = OP_BEGIN;
    @(posedge clk_i); @(negedge clk_i);
    cmd_op_i = OP_WATCH_W; cmd_addr_i = 32'h1000_0040;
    @(posedge clk_i); @(negedge clk_i);
    cmd_valid_i = 0; snp_valid_i = 1; snp_write_i = 1; snp_addr_i = 32'h0000_0040;
    @(posedge clk_i); @(negedge clk_i);
    check(tx_active_o && !abort_valid_o, "R1 high bits distinct", outs(), 32'h0);
    snp_addr_i = 32'h1000_007f;
    @(posedge clk_i); @(negedge clk_i);
    snp_valid_i = 0;
    check(rollback_valid_o && rollback_line_o == LINE_W'(32'h1000_0040 >> 6),
          "R1 same line any offset", 32'(rollback_line_o), 32'h0040_0001);
    @(posedge clk_i); @(negedge clk_i);
    check(abort_valid_o && abort_code_o == 8'h10, "R4 write-set conflict code",
          32'(abort_code_o), 32'h10);
    @(posedge clk_i); @(negedge clk_i);

    // R9: conflict outranks external and capacity is lowest
    cmd_valid_i = 1; cmd_op_i = OP_BEGIN;
    @(posedge clk_i); @(negedge clk_i);
    cmd_op_i = OP_WATCH_R; cmd_addr_i = 32'h0000_0200;
    @(posedge clk_i); @(negedge clk_i);
    cmd_valid_i = 0; ext_abort_i = 1; snp_valid_i = 1; snp_write_i = 1; snp_addr_i = 32'h0000_0200;
    @(posedge clk_i); @(negedge clk_i);
    idle_inputs();
    check(abort_valid_o && abort_code_o == 8'h10, "R9 conflict first",
          32'(abort_code_o), 32'h10);
    @(posedge clk_i); @(negedge clk_i);

    // R2: reset in mid transaction returns to idle
    cmd_valid_i = 1; cmd_op_i = OP_BEGIN;
    @(posedge clk_i); @(negedge clk_i);
    idle_inputs();
    rst_ni = 0;
    #1;
    check(!tx_active_o && !commit_done_o, "R2 async reset", outs(), 0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule